// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

The block turns one burst request into the run of column addresses that an SDRAM access walks through. A request carries a starting column, a 3-bit burst length code and an order bit. The block then emits one column per accepted beat on a valid/ready stream, and flags the final beat. Fixed bursts stay inside an aligned block whose size equals the burst length. The column bits above that block are held from the start column. The bits below it step either sequentially or in interleaved order. A full-page burst steps through the whole page, wraps at the page edge and continues until a terminate request ends it. Terminate can also cut any fixed burst short.

The column width `COL_W` is 9 for a 512-column page or 8 for a 256-column page. The stream follows valid/ready rules. A beat is accepted on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current beat and its column are held unchanged. `term` is a command rather than a stream signal. It ends the burst at the next edge whether or not the beat shown in that cycle was accepted.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `out_valid` and `out_err` are low.
- R2: A `start` pulse seen while no burst is running is accepted. Beat 0 appears with `out_valid` high on the next clock, and its column equals `start_col`.
- R3: The length codes are: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page. `out_last` is high on the final beat of a fixed burst. `out_valid` is low on the clock after that beat is accepted, unless a new start is taken.
- R4: When `burst_il` is 0 (sequential), beat n of a fixed burst of length L has column bits below log2(L) equal to (start low bits + n) mod L. All higher bits equal those of `start_col`.
- R5: When `burst_il` is 1 (interleaved), beat n of a fixed burst has low bits equal to (start low bits XOR n), with the higher bits held.
- R6: A full-page burst always runs in sequential order, whatever the value of `burst_il`. Beat n is (start_col + n) mod 2^COL_W, and the burst does not end by itself.
- R7: When `term` is high while a beat is valid, that beat shows `out_last` high, and `out_valid` is low on the next clock unless a new start is taken. `term` has no effect while idle.
- R8: A `start` pulse that arrives during a running burst is ignored when `term` is low. When `term` is high in the same cycle, the new burst's beat 0 follows on the next clock.
- R9: The reserved length codes 100, 101 and 110 give a 1-beat burst. `out_err` goes high from that beat onwards and stays high until the next accepted start.
- R10: While `out_valid` is high and `out_ready` is low, with `term` low, the beat is held and `out_col` does not change. The burst advances only on accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request strobe |
| start_col | input | COL_W | Starting column of the burst |
| bl_code | input | 3 | Burst length code |
| burst_il | input | 1 | Order: 0 sequential, 1 interleaved |
| term | input | 1 | Ends the running burst after the current cycle |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A column beat is present |
| out_col | output | COL_W | Column address of the current beat |
| out_last | output | 1 | Current beat is the final one |
| out_err | output | 1 | The last accepted request used a reserved length code |

## Verification
A wrong beat counter or a wrong captured mask shows at the ports on the first beat that follows the error. The symptoms are a column leaving its aligned block, a wrap that lands on the wrong column, or `out_last` appearing too early or too late. A busy flag that fails to clear shows as `out_valid` remaining high one clock after a last beat or a terminate. A start that is wrongly accepted mid-burst replaces the expected column on the very next beat. Under back-pressure, a counter that advances without a handshake shows as a column that changes while `out_ready` is low.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } blen_code_e;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             rsvd
);
  import sdram_col_pkg::*;

  logic [1:0] lg;

  always_comb begin
    lg   = 2'd0;
    full = 1'b0;
    rsvd = 1'b0;
    case (blen_code_e'(code))
      BLC_1:    lg = 2'd0;
      BLC_2:    lg = 2'd1;
      BLC_4:    lg = 2'd2;
      BLC_8:    lg = 2'd3;
      BLC_PAGE: full = 1'b1;
      default:  rsvd = 1'b1;
    endcase
  end

  // One mask bit per column bit: set below the block boundary.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask[i] = full | (!rsvd && (int'(lg) > i));
  end
endmodule

// File: rtl/col_beat_ctr.sv
module col_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic             adv,
  input  logic             at_end,
  output logic             busy,
  output logic [COL_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (load) begin
      busy <= 1'b1;
      beat <= '0;
    end else if (busy && stop) begin
      busy <= 1'b0;
    end else if (busy && adv) begin
      if (at_end) busy <= 1'b0;
      else        beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/col_addr_form.sv
module col_addr_form #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_off;
  logic [COL_W-1:0] il_off;

  always_comb begin
    seq_off = (base + beat) & mask;
    il_off  = (base ^ beat) & mask;
    col     = (base & ~mask) | (il ? il_off : seq_off);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             burst_il,
  input  logic             term,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col,
  output logic             out_last,
  output logic             out_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_rsvd;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             il_q;
  logic             err_q;

  logic             busy;
  logic [COL_W-1:0] beat;
  logic             accept;
  logic             at_end;

  col_len_decode #(.COL_W(COL_W)) u_dec (
    .code (bl_code),
    .mask (dec_mask),
    .full (dec_full),
    .rsvd (dec_rsvd)
  );

  assign accept = start && (!busy || term);
  assign at_end = !full_q && (beat == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      base_q <= start_col;
      mask_q <= dec_mask;
      full_q <= dec_full;
      il_q   <= burst_il && !dec_full;
      err_q  <= dec_rsvd;
    end
  end

  col_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .stop   (term),
    .adv    (out_ready),
    .at_end (at_end),
    .busy   (busy),
    .beat   (beat)
  );

  col_addr_form #(.COL_W(COL_W)) u_addr (
    .base (base_q),
    .mask (mask_q),
    .il   (il_q),
    .beat (beat),
    .col  (out_col)
  );

  assign out_valid = busy;
  assign out_last  = busy && (at_end || term);
  assign out_err   = err_q;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             term,
  input logic             out_ready,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col,
  input logic             out_last,
  input logic             out_err
);
  assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !out_valid |=> out_valid && (out_col == $past(start_col)));

  assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !start |=> !out_valid);

  assert_term_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && term && !start |=> !out_valid);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && !term && !out_last |=> out_valid && $stable(out_err));

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !term |=> out_valid && $stable(out_col));
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .term      (term),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_col   (out_col),
  .out_last  (out_last),
  .out_err   (out_err)
);

// File: tb/sim_sdram_col_seq.sv
`timescale 1ns/1ps
module sim_sdram_col_seq;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             burst_il = 1'b0;
  logic             term = 1'b0;
  logic             out_ready = 1'b1;
  logic             out_valid;
  logic [COL_W-1:0] out_col;
  logic             out_last;
  logic             out_err;

  always #2 clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .burst_il(burst_il), .term(term),
    .out_ready(out_ready), .out_valid(out_valid), .out_col(out_col),
    .out_last(out_last), .out_err(out_err)
  );

  typedef struct {
    logic [COL_W-1:0] col;
    bit               last;
    string            tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int code, input bit il, input int n);
    int len, base, off;
    if (code == 7) return (s + n) % (1 << COL_W);
    len  = (code <= 3) ? (1 << code) : 1;
    base = s - (s % len);
    off  = s % len;
    return base + (il ? (off ^ n) : ((off + n) % len));
  endfunction

  task automatic push_burst(input int s, input int code, input bit il,
                            input int nlast, input string tag);
    for (int n = 0; n <= nlast; n++)
      q.push_back('{col: exp_col(s, code, il, n), last: (n == nlast), tag: tag});
  endtask

  // Scoreboard monitor: compares each accepted beat; checks stall hold.
  logic [COL_W-1:0] held_col;
  bit               stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled && out_valid)
        chk(out_col == held_col, "R10", "column changed under stall", out_col, held_col);
      stalled  = out_valid && !out_ready && !term;
      held_col = out_col;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected beat", out_col, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(out_col == it.col, it.tag, "column", out_col, it.col);
          chk(out_last == it.last, it.tag, "last flag", out_last, it.last);
        end
      end
    end
  end

  task automatic run_burst(input int s, input int code, input bit il,
                           input int nbeats, input int term_at, input string tag);
    int nlast;
    nlast = (term_at >= 0) ? term_at : nbeats - 1;
    push_burst(s, code, il, nlast, tag);
    @(posedge clk); #1;
    start = 1'b1; start_col = COL_W'(s); bl_code = 3'(code); burst_il = il; out_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k <= nlast; k++) begin
      term = (k == term_at);
      @(posedge clk); #1;
      term = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, tag, "valid after burst end", out_valid, 0);
    chk(q.size() == 0, tag, "beats missing", q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_err == 1'b0, "R1", "err in reset", out_err, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R2 R3: single beat
    run_burst('h1A5, 0, 0, 1, -1, "R2");
    // R4: sequential wraps inside blocks of 2, 4, 8
    run_burst('h0C3, 1, 0, 2, -1, "R4");
    run_burst('h106, 2, 0, 4, -1, "R4");
    run_burst('h0FD, 3, 0, 8, -1, "R3");
    // R5: interleaved order
    run_burst('h105, 2, 1, 4, -1, "R5");
    run_burst('h0FD, 3, 1, 8, -1, "R5");
    // R6: full page ignores the order bit, wraps at 512
    run_burst('h1FD, 7, 1, 0, 5, "R6");
    chk(out_err == 1'b0, "R9", "err after normal burst", out_err, 0);
    // R7: early stop of a fixed burst
    run_burst('h0F0, 3, 0, 8, 2, "R7");
    // R7: terminate while idle does nothing
    @(posedge clk); #1; term = 1'b1;
    @(posedge clk); #1; term = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid after idle term", out_valid, 0);

    // R9: reserved codes
    for (int c = 4; c <= 6; c++) begin
      run_burst('h123, c, 0, 1, -1, "R9");
      chk(out_err == 1'b1, "R9", "err for reserved code", out_err, 1);
    end
    run_burst('h040, 1, 0, 2, -1, "R9");
    chk(out_err == 1'b0, "R9", "err cleared by next start", out_err, 0);

    // R8: ignored start mid-burst, then terminate with restart
    push_burst('h010, 7, 0, 6, "R8");
    push_burst('h02A, 2, 0, 3, "R8");
    @(posedge clk); #1;
    start = 1'b1; start_col = 'h010; bl_code = 3'd7; burst_il = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k <= 6; k++) begin
      if (k == 3) begin start = 1'b1; start_col = 'h005; bl_code = 3'd5; end
      if (k == 6) begin start = 1'b1; term = 1'b1; start_col = 'h02A; bl_code = 3'd2; end
      if (k == 4) begin
        @(negedge clk);
        chk(out_err == 1'b0, "R8", "ignored start changed err", out_err, 0);
      end
      @(posedge clk); #1;
      start = 1'b0; term = 1'b0;
    end
    repeat (4) begin @(posedge clk); #1; end
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "valid after restarted burst", out_valid, 0);
    chk(q.size() == 0, "R8", "beats missing", q.size(), 0);

    // R10: back-pressure on an interleaved burst of 8
    push_burst('h0FD, 3, 1, 7, "R10");
    @(posedge clk); #1;
    start = 1'b1; start_col = 'h0FD; bl_code = 3'd3; burst_il = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int r = 0; q.size() > 0 && r < 100; r++) begin
      out_ready = ((r % 3) != 1);
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "valid after stalled burst", out_valid, 0);
    chk(q.size() == 0, "R10", "beats missing", q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule